// File: doc/BRIEF.md
# Byte Register Port with Atomic Bit Set and Clear

This block is the host-facing register port of a network adapter. Each host access is one byte wide and carries a 9-bit address. That address names a target byte register, an operation, and an area. The operation is coded in the address itself. A single bus write can therefore replace a register, clear bits in it (bitwise AND with the data byte) or set bits in it (bitwise OR with the data byte). Firmware on the host never needs a read-modify-write sequence that could race with the adapter's own status updates.

The control area holds several registers:
- a shared-RAM relocation pair that places the shared RAM base and reports the RAM size;
- a host interrupt status pair, where the adapter-side engine posts events through an event input and the host acknowledges them with atomic clears;
- a paging register;
- general-purpose scratch bytes.

Two identification areas return the adapter's encoded node address and a fixed test pattern. Accesses that are not allowed are dropped and flag an access error. These are any access to a hole in the map, any access to the reserved area, any modify to an identification area, and any modify that tries to change a read-only bit.

Top module: `mmio_atomic_port`

## Requirements
- R1: After a synchronous active-high reset, every writable bit is zero. `irq`, `paging_en`, `rd_valid` and `ram_base` are 0. Control register 0x01 reads as the RAM size code placed in bits 3:2.
- R2: The fields of `req_addr` are as follows. Bits 4:0 are the register index. Bits 6:5 are the operation: 00 write, 01 AND, 10 OR, 11 read. Bits 8:7 are the area: 00 control, 01 reserved, 10 node-address identification, 11 test-pattern identification.
- R3: In the control area, write, AND and OR each change only the writable bits of the target register. The writable masks are:
  - 0x00: 0xFE
  - 0x01: 0xF3
  - 0x08: 0x5D
  - 0x09: 0x7E
  - 0x18: 0xFF
  - 0x02-0x07 and 0x0A-0x0F: 0xFF
- R4: A read request returns its byte on `rd_data` with `rd_valid` high in the cycle after the request. The byte is the register value from before any update made in that same cycle. `rd_valid` is low after any non-read cycle.
- R5: Bits 7:1 of register 0x00 drive `ram_base[19:13]`. Bits 12:0 of `ram_base` are zero, and bit 0 of register 0x00 reads zero. `ram_base` changes only after a modify to control register 0x00.
- R6: Bits 3:2 of register 0x01 are read-only and always return the RAM size code: 00 is 8 KiB, 01 is 16 KiB, 10 is 32 KiB, 11 is 64 KiB.
- R7: `paging_en` is high exactly when bits 7 and 6 of register 0x18 are both set.
- R8: Control indices 0x10-0x17 and 0x19-0x1F are unmapped. They read zero, and any access to them changes no register and sets the access-error bit, bit 2 of register 0x08.
- R9: The node-address area returns byte i of `NODE_ADDR` at offsets 0-5, most significant byte at offset 0, and zero at higher offsets. The test-pattern area returns 0x55 at even offsets and 0xAA at odd offsets. A modify to either identification area is ignored and sets the access-error bit. Any access to the reserved area reads zero and sets the access-error bit.
- R10: A control-area modify whose result differs from the current value in a read-only bit keeps the read-only bits, updates the writable bits, and sets the access-error bit.
- R11: In each cycle, `evt_set` bits 6:1 are ORed into register 0x09 after the host operation is applied. A host clear of a bit and an event setting that bit in the same cycle leave the bit set.
- R12: `irq` is high when bit 6 of register 0x08 is set and at least one of the following bits is set: bits 4:2 of register 0x08, or bits 6:1 of register 0x09. Otherwise `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host access in this cycle |
| req_addr | input | 9 | Area, operation and register index |
| req_wdata | input | 8 | Data byte for write, AND or OR |
| evt_set | input | 8 | Adapter-side event bits posted into register 0x09 |
| rd_valid | output | 1 | `rd_data` holds the result of last cycle's read |
| rd_data | output | 8 | Read result |
| ram_base | output | 20 | Shared RAM base address |
| paging_en | output | 1 | Shared RAM paging enabled |
| irq | output | 1 | Host interrupt request |

## Verification
Two functions can land on the same edge:
- the adapter's event posting into register 0x09 and a host AND or write to that register;
- an invalid access raising the error bit while register 0x08 holds bits the host set earlier.

The bench provokes the first case with directed cycles that clear 0x09 with a zero byte while `evt_set` carries the same bits. It also overlaps random events with random host operations. The bench judges the outcome by reading 0x09 back and by watching `irq`, against a model in which the event is merged after the host result. It also reads 0x09 in a cycle that posts an event, to confirm the read returns the value from before the merge.

// File: rtl/mmio_port_pkg.sv
package mmio_port_pkg;

    localparam int BYTE_W      = 8;
    localparam int IDX_W       = 5;
    localparam int OP_W        = 2;
    localparam int AREA_W      = 2;
    localparam int ADDR_W      = IDX_W + OP_W + AREA_W;
    localparam int NREG        = 1 << IDX_W;
    localparam int LOW_BANK    = 16;
    localparam int RAM_ADDR_W  = 20;
    localparam int BASE_LSB    = 13;

    localparam int IX_RELOC_EV = 0;
    localparam int IX_RELOC_OD = 1;
    localparam int IX_HSTS_EV  = 8;
    localparam int IX_HSTS_OD  = 9;
    localparam int IX_PAGE     = 24;

    localparam int ERR_BIT     = 2;
    localparam int INTEN_BIT   = 6;

    localparam logic [BYTE_W-1:0] IRQ_EV_MASK  = 8'h1C;
    localparam logic [BYTE_W-1:0] PAGE_EN_MASK = 8'hC0;

    typedef enum logic [OP_W-1:0] {
        OP_WR  = 2'b00,
        OP_AND = 2'b01,
        OP_OR  = 2'b10,
        OP_RD  = 2'b11
    } op_e;

    typedef enum logic [AREA_W-1:0] {
        AR_CTRL = 2'b00,
        AR_RSVD = 2'b01,
        AR_IDA  = 2'b10,
        AR_IDB  = 2'b11
    } area_e;

    typedef struct packed {
        op_e              op;
        area_e            area;
        logic [IDX_W-1:0] idx;
        logic             rd;
        logic             modify;
        logic             ctrl_ok;
        logic             bad;
    } dec_t;

    function automatic logic reg_mapped(input logic [IDX_W-1:0] idx);
        return (int'(idx) < LOW_BANK) || (int'(idx) == IX_PAGE);
    endfunction

    function automatic logic [BYTE_W-1:0] wr_mask(input logic [IDX_W-1:0] idx);
        logic [BYTE_W-1:0] m;
        case (int'(idx))
            IX_RELOC_EV: m = 8'hFE;
            IX_RELOC_OD: m = 8'hF3;
            IX_HSTS_EV:  m = 8'h5D;
            IX_HSTS_OD:  m = 8'h7E;
            IX_PAGE:     m = 8'hFF;
            default:     m = (int'(idx) < LOW_BANK) ? 8'hFF : 8'h00;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_port_pkg::*;
(
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);

    logic [IDX_W-1:0] idx;
    op_e              op;
    area_e            area;
    logic             mapped;

    always_comb begin
        idx    = addr[IDX_W-1:0];
        op     = op_e'(addr[IDX_W+OP_W-1:IDX_W]);
        area   = area_e'(addr[ADDR_W-1:IDX_W+OP_W]);
        mapped = reg_mapped(idx);

        dec.op      = op;
        dec.area    = area;
        dec.idx     = idx;
        dec.rd      = valid && (op == OP_RD);
        dec.modify  = valid && (op != OP_RD);
        dec.ctrl_ok = (area == AR_CTRL) && mapped;
        dec.bad     = valid && ((area == AR_RSVD)
                              || ((area == AR_CTRL) && !mapped)
                              || (area[1] && (op != OP_RD)));
    end

endmodule

// File: rtl/mmio_atomic_alu.sv
module mmio_atomic_alu
    import mmio_port_pkg::*;
(
    input  op_e               op,
    input  logic [BYTE_W-1:0] cur,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] wmask,
    output logic [BYTE_W-1:0] nxt,
    output logic              ro_viol
);

    logic [BYTE_W-1:0] res;

    always_comb begin
        case (op)
            OP_WR:   res = wdata;
            OP_AND:  res = cur & wdata;
            OP_OR:   res = cur | wdata;
            default: res = cur;
        endcase
        nxt     = (cur & ~wmask) | (res & wmask);
        ro_viol = |((res ^ cur) & ~wmask);
    end

endmodule

// File: rtl/mmio_regs.sv
module mmio_regs
    import mmio_port_pkg::*;
#(
    parameter int                  ID_BYTES      = 6,
    parameter logic [1:0]          RAM_SIZE_CODE = 2'b10,
    parameter logic [8*ID_BYTES-1:0] NODE_ADDR   = 48'h021A2B3C4D5E
) (
    input  logic              clk,
    input  logic              rst,
    input  dec_t              dec,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [BYTE_W-1:0] evt_set,
    output logic              rd_valid,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-2:0] base_field,
    output logic [BYTE_W-1:0] page_byte,
    output logic [BYTE_W-1:0] sts_even,
    output logic [BYTE_W-1:0] sts_odd
);

    localparam logic [BYTE_W-1:0] SIZE_BITS = {4'b0000, RAM_SIZE_CODE, 2'b00};

    typedef struct packed {
        logic [NREG-1:0][BYTE_W-1:0] regs;
        logic                        rd_v;
        logic [BYTE_W-1:0]           rd;
    } state_t;

    state_t state_d, state_q;

    logic [NREG-1:0][BYTE_W-1:0] view;
    logic [NREG-1:0][BYTE_W-1:0] id_a;
    logic [NREG-1:0][BYTE_W-1:0] id_b;

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        localparam logic [IDX_W-1:0] GI = IDX_W'(g);
        if (g == IX_RELOC_OD) begin : g_ro
            assign view[g] = (state_q.regs[g] & wr_mask(GI)) | SIZE_BITS;
        end else begin : g_rw
            assign view[g] = state_q.regs[g] & wr_mask(GI);
        end
        if (g < ID_BYTES) begin : g_node
            assign id_a[g] = NODE_ADDR[8*(ID_BYTES-g)-1 -: 8];
        end else begin : g_pad
            assign id_a[g] = '0;
        end
        assign id_b[g] = (g % 2 == 1) ? 8'hAA : 8'h55;
    end

    logic [BYTE_W-1:0] cur;
    logic [BYTE_W-1:0] wm;
    logic [BYTE_W-1:0] alu_nxt;
    logic              ro_viol;

    assign cur = view[dec.idx];
    assign wm  = wr_mask(dec.idx);

    mmio_atomic_alu u_alu (
        .op      (dec.op),
        .cur     (cur),
        .wdata   (wdata),
        .wmask   (wm),
        .nxt     (alu_nxt),
        .ro_viol (ro_viol)
    );

    logic              err;
    logic [BYTE_W-1:0] rsel;

    always_comb begin
        state_d = state_q;

        err = dec.bad || (dec.modify && dec.ctrl_ok && ro_viol);

        case (dec.area)
            AR_CTRL: rsel = dec.ctrl_ok ? cur : '0;
            AR_IDA:  rsel = id_a[dec.idx];
            AR_IDB:  rsel = id_b[dec.idx];
            default: rsel = '0;
        endcase

        if (dec.modify && dec.ctrl_ok) begin
            state_d.regs[dec.idx] = alu_nxt & wm;
        end

        state_d.regs[IX_HSTS_OD] = state_d.regs[IX_HSTS_OD]
                                 | (evt_set & wr_mask(IDX_W'(IX_HSTS_OD)));

        if (err) begin
            state_d.regs[IX_HSTS_EV][ERR_BIT] = 1'b1;
        end

        state_d.rd_v = dec.rd;
        if (dec.rd) begin
            state_d.rd = rsel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_valid   = state_q.rd_v;
    assign rd_data    = state_q.rd;
    assign base_field = view[IX_RELOC_EV][BYTE_W-1:1];
    assign page_byte  = view[IX_PAGE];
    assign sts_even   = view[IX_HSTS_EV];
    assign sts_odd    = view[IX_HSTS_OD];

endmodule

// File: rtl/mmio_atomic_port.sv
module mmio_atomic_port
    import mmio_port_pkg::*;
#(
    parameter int                    ID_BYTES      = 6,
    parameter logic [1:0]            RAM_SIZE_CODE = 2'b10,
    parameter logic [8*ID_BYTES-1:0] NODE_ADDR     = 48'h021A2B3C4D5E
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [BYTE_W-1:0]     req_wdata,
    input  logic [BYTE_W-1:0]     evt_set,
    output logic                  rd_valid,
    output logic [BYTE_W-1:0]     rd_data,
    output logic [RAM_ADDR_W-1:0] ram_base,
    output logic                  paging_en,
    output logic                  irq
);

    dec_t              dec;
    logic [BYTE_W-2:0] base_field;
    logic [BYTE_W-1:0] page_byte;
    logic [BYTE_W-1:0] sts_even_q;
    logic [BYTE_W-1:0] sts_odd_q;

    mmio_decode u_decode (
        .valid (req_valid),
        .addr  (req_addr),
        .dec   (dec)
    );

    mmio_regs #(
        .ID_BYTES      (ID_BYTES),
        .RAM_SIZE_CODE (RAM_SIZE_CODE),
        .NODE_ADDR     (NODE_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .dec        (dec),
        .wdata      (req_wdata),
        .evt_set    (evt_set),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .base_field (base_field),
        .page_byte  (page_byte),
        .sts_even   (sts_even_q),
        .sts_odd    (sts_odd_q)
    );

    assign ram_base  = {base_field, {BASE_LSB{1'b0}}};
    assign paging_en = ((page_byte & PAGE_EN_MASK) == PAGE_EN_MASK);
    assign irq       = sts_even_q[INTEN_BIT]
                     & ((|(sts_even_q & IRQ_EV_MASK))
                      | (|(sts_odd_q & wr_mask(IDX_W'(IX_HSTS_OD)))));

endmodule

// File: rtl/mmio_atomic_port_checker.sv
module mmio_atomic_port_checker (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [8:0]  req_addr,
    input logic [7:0]  evt_set,
    input logic        rd_valid,
    input logic [19:0] ram_base,
    input logic        irq,
    input logic [7:0]  sts_even,
    input logic [7:0]  sts_odd
);

    logic is_rd;
    logic bad_ctrl;
    assign is_rd    = req_valid && (req_addr[6:5] == 2'b11);
    assign bad_ctrl = req_valid && (req_addr[8:7] == 2'b00)
                    && (req_addr[4] == 1'b1) && (req_addr[4:0] != 5'd24);

    p_rd_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        is_rd |=> rd_valid);

    p_no_rd_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !is_rd |=> !rd_valid);

    p_evt_sets_r11: assert property (@(posedge clk) disable iff (rst)
        (|(evt_set & 8'h7E)) |=>
            ((sts_odd & ($past(evt_set) & 8'h7E)) == ($past(evt_set) & 8'h7E)));

    p_bad_reg_err_r8: assert property (@(posedge clk) disable iff (rst)
        bad_ctrl |=> sts_even[2]);

    p_id_modify_err_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[8] && (req_addr[6:5] != 2'b11)) |=> sts_even[2]);

    p_rsvd_err_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_addr[8:7] == 2'b01)) |=> sts_even[2]);

    p_base_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && (req_addr[8:7] == 2'b00) && (req_addr[4:0] == 5'd0)
          && (req_addr[6:5] != 2'b11)) |=> $stable(ram_base));

    p_irq_gate_r12: assert property (@(posedge clk) disable iff (rst)
        !sts_even[6] |-> !irq);

endmodule

bind mmio_atomic_port mmio_atomic_port_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .evt_set   (evt_set),
    .rd_valid  (rd_valid),
    .ram_base  (ram_base),
    .irq       (irq),
    .sts_even  (sts_even_q),
    .sts_odd   (sts_odd_q)
);

// File: tb/mmio_atomic_port_bench.sv
module mmio_atomic_port_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [47:0] NODE       = 48'h021A2B3C4D5E;
    localparam logic [1:0]  SIZE       = 2'b10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [8:0]  req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  evt_set = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [19:0] ram_base;
    logic        paging_en;
    logic        irq;

    mmio_atomic_port #(
        .ID_BYTES      (6),
        .RAM_SIZE_CODE (SIZE),
        .NODE_ADDR     (NODE)
    ) u_mmio_atomic_port (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .evt_set   (evt_set),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .ram_base  (ram_base),
        .paging_en (paging_en),
        .irq       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int         n_chk  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;
    logic [7:0] mdl [32];
    logic [7:0] last_rd;

    function automatic logic [7:0] b_wm(input int i);
        case (i)
            0:  return 8'hFE;
            1:  return 8'hF3;
            8:  return 8'h5D;
            9:  return 8'h7E;
            24: return 8'hFF;
            default: return (i < 16) ? 8'hFF : 8'h00;
        endcase
    endfunction

    function automatic logic b_ok(input int i);
        return (i < 16) || (i == 24);
    endfunction

    function automatic logic [7:0] b_view(input int i);
        return (mdl[i] & b_wm(i)) | ((i == 1) ? {4'b0, SIZE, 2'b00} : 8'h00);
    endfunction

    function automatic logic [7:0] b_read(input int area, input int i);
        case (area)
            0: return b_ok(i) ? b_view(i) : 8'h00;
            2: return (i < 6) ? NODE[8*(6-i)-1 -: 8] : 8'h00;
            3: return (i % 2 == 1) ? 8'hAA : 8'h55;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic b_irq();
        logic [7:0] e;
        logic [7:0] o;
        e = b_view(8);
        o = b_view(9);
        return e[6] & ((|e[4:2]) | (|o[6:1]));
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input int area, input int opc, input int idx,
                         input logic [7:0] wd, input logic [7:0] evt,
                         input string tag);
        logic [7:0] exp_rd;
        logic [7:0] cur;
        logic [7:0] res;
        logic [7:0] wm;
        bit         err;
        exp_rd = b_read(area, idx);
        err = 1'b0;
        if (area == 1) err = 1'b1;
        else if (area >= 2 && opc != 3) err = 1'b1;
        else if (area == 0 && !b_ok(idx)) err = 1'b1;
        else if (area == 0 && opc != 3) begin
            cur = b_view(idx);
            wm  = b_wm(idx);
            res = (opc == 0) ? wd : (opc == 1) ? (cur & wd) : (cur | wd);
            if (((res ^ cur) & ~wm) != 8'h00) err = 1'b1;
            mdl[idx] = res & wm;
        end
        mdl[9] = mdl[9] | (evt & 8'h7E);
        if (err) mdl[8] = mdl[8] | 8'h04;

        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = {2'(area), 2'(opc), 5'(idx)};
        req_wdata = wd;
        evt_set   = evt;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        evt_set   = 8'h00;
        if (opc == 3) begin
            check(rd_valid && rd_data == exp_rd, {tag, " R4 read data"},
                  {23'b0, rd_valid, rd_data}, {24'h000001, exp_rd});
            last_rd = rd_data;
        end else begin
            check(!rd_valid, {tag, " R4 no read strobe"}, 32'(rd_valid), 32'd0);
        end
        check(ram_base == {mdl[0][7:1], 13'b0}, {tag, " R5 ram_base"},
              32'(ram_base), 32'({mdl[0][7:1], 13'b0}));
        check(paging_en == (mdl[24][7] & mdl[24][6]), {tag, " R7 paging_en"},
              32'(paging_en), 32'(mdl[24][7] & mdl[24][6]));
        check(irq == b_irq(), {tag, " R12 irq"}, 32'(irq), 32'(b_irq()));
    endtask

    task automatic rd_lit(input int area, input int idx, input logic [7:0] exp,
                          input string tag);
        do_op(area, 3, idx, 8'h00, 8'h00, tag);
        check(last_rd == exp, {tag, " literal"}, 32'(last_rd), 32'(exp));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
        last_rd = 8'h00;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1: reset state at the ports
        check(!irq && !paging_en && !rd_valid && ram_base == 20'h0,
              "R1 reset outputs", {irq, paging_en, rd_valid, ram_base},
              32'd0);
        rd_lit(0, 1, 8'h08, "R1 R6 size code after reset");
        rd_lit(0, 8, 8'h00, "R1 status even after reset");
        rd_lit(0, 2, 8'h00, "R1 scratch after reset");

        // R2 R3: write, AND, OR on a scratch byte
        do_op(0, 0, 2, 8'hA5, 8'h00, "R2 R3 write");
        do_op(0, 1, 2, 8'h0F, 8'h00, "R3 and");
        rd_lit(0, 2, 8'h05, "R3 after and");
        do_op(0, 2, 2, 8'hF0, 8'h00, "R3 or");
        rd_lit(0, 2, 8'hF5, "R2 R3 after or");

        // R5: relocation base
        do_op(0, 0, 0, 8'hFE, 8'h00, "R5 base write");
        check(ram_base == 20'hFE000, "R5 base literal", 32'(ram_base), 32'hFE000);
        rd_lit(0, 8, 8'h00, "R5 no error on legal write");
        do_op(0, 0, 0, 8'h43, 8'h00, "R10 base ro bit0");
        rd_lit(0, 0, 8'h42, "R5 R10 bit0 held zero");
        rd_lit(0, 8, 8'h04, "R10 error raised");
        do_op(0, 1, 8, 8'hFB, 8'h00, "R10 clear error");
        rd_lit(0, 8, 8'h00, "R10 error cleared");

        // R6: size bits are read-only
        do_op(0, 1, 1, 8'h00, 8'h00, "R6 and size");
        rd_lit(0, 1, 8'h08, "R6 size kept");
        rd_lit(0, 8, 8'h04, "R6 R10 error");
        do_op(0, 0, 8, 8'h00, 8'h00, "R6 clear error");

        // R7: paging needs both top bits
        do_op(0, 2, 24, 8'h80, 8'h00, "R7 one bit");
        check(!paging_en, "R7 one bit no paging", 32'(paging_en), 32'd0);
        do_op(0, 2, 24, 8'h40, 8'h00, "R7 both bits");
        check(paging_en, "R7 paging on", 32'(paging_en), 32'd1);
        do_op(0, 1, 24, 8'h7F, 8'h00, "R7 clear bit");
        check(!paging_en, "R7 paging off", 32'(paging_en), 32'd0);

        // R8: unmapped control registers
        do_op(0, 0, 18, 8'hFF, 8'h00, "R8 write hole");
        rd_lit(0, 18, 8'h00, "R8 hole reads zero");
        rd_lit(0, 8, 8'h04, "R8 error set");
        do_op(0, 0, 8, 8'h00, 8'h00, "R8 clear");
        do_op(0, 2, 25, 8'h01, 8'h00, "R8 or hole 0x19");
        rd_lit(0, 8, 8'h04, "R8 error for 0x19");
        do_op(0, 0, 8, 8'h00, 8'h00, "R8 clear 2");

        // R9: identification and reserved areas
        for (int i = 0; i < 7; i++) rd_lit(2, i, b_read(2, i), "R9 node byte");
        rd_lit(2, 0, 8'h02, "R9 node msb");
        rd_lit(3, 0, 8'h55, "R9 pattern even");
        rd_lit(3, 7, 8'hAA, "R9 pattern odd");
        rd_lit(0, 8, 8'h00, "R9 id reads no error");
        do_op(2, 0, 1, 8'h00, 8'h00, "R9 write id");
        rd_lit(2, 1, 8'h1A, "R9 id unchanged");
        rd_lit(0, 8, 8'h04, "R9 id write error");
        do_op(0, 0, 8, 8'h00, 8'h00, "R9 clear");
        rd_lit(1, 3, 8'h00, "R9 reserved zero");
        rd_lit(0, 8, 8'h04, "R9 reserved error");
        do_op(0, 0, 8, 8'h00, 8'h00, "R9 clear 2");

        // R11 R12: event set against host clear in the same cycle
        do_op(0, 0, 8, 8'h40, 8'h00, "R12 enable");
        check(!irq, "R12 idle irq low", 32'(irq), 32'd0);
        do_op(0, 3, 9, 8'h00, 8'h02, "R4 read during event");
        check(last_rd == 8'h00, "R4 pre-update value", 32'(last_rd), 32'd0);
        check(irq, "R12 irq after event", 32'(irq), 32'd1);
        do_op(0, 1, 9, 8'h00, 8'h02, "R11 clear vs set");
        rd_lit(0, 9, 8'h02, "R11 set wins");
        do_op(0, 0, 9, 8'h00, 8'hFF, "R11 write vs all events");
        rd_lit(0, 9, 8'h7E, "R11 masked events");
        do_op(0, 0, 9, 8'h00, 8'h00, "R11 clear");
        check(!irq, "R12 irq cleared", 32'(irq), 32'd0);
        do_op(0, 0, 8, 8'h00, 8'h00, "R12 disable");

        // Random phase
        void'($urandom(32'd1234));
        for (int k = 0; k < 600; k++) begin
            int area;
            int opc;
            int idx;
            logic [7:0] wd;
            logic [7:0] evt;
            area = (($urandom % 8) < 6) ? 0 : int'($urandom % 4);
            opc  = int'($urandom % 4);
            idx  = (($urandom % 4) == 0) ? (($urandom % 2 == 0) ? 8 : 9) : int'($urandom % 32);
            wd   = 8'($urandom);
            evt  = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            do_op(area, opc, idx, wd, evt, "R3 R10 R11 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule